// File: doc/BRIEF.md
# Power-Fail Time-Save Controller

This block watches two supply monitors: a power-fail comparator and a comparator that flags when the backup battery rises above the main supply. Both are treated as a loss of main power. After a short glitch filter accepts the failure, the block does three things. It raises a power-fail interrupt. It locks out host register writes. When saving is enabled, it writes the running clock counters into a small time-save RAM.

The time fields reach the block on one parallel bus, with one byte per field. The whole bus is latched in the cycle the failure is accepted. The fields are then written to the save RAM one byte per cycle, in a fixed order from hundredths up to month. A status register reports these conditions:
- the first-battery-application flag
- whether system power is present
- a low-battery condition
- the pending interrupt
- save completion
- the lockout

Software clears flags by writing ones to them. The lockout ends only after power has been back for a programmable settle time and software has then read the status register.

Top module: `pwrfail_tsave`

## Requirements
- R1: Each monitor input passes through a two-flop synchronizer. A failure is accepted only after the synchronized failure level has been high for 4 consecutive cycles. A pulse of 3 or fewer cycles is ignored. For an input that rises and stays high, the lock and the interrupt appear 7 clock edges after the first edge that samples the input.
- R2: The input `bat_over_main` high is handled exactly like `pf_in` high, with the same filter and timing.
- R3: Accepting a failure sets status bit 3 and drives `irq_pf` high. Both stay high, even across a status read and the release of the lock, until a status write with bit 3 set.
- R4: While the block is locked, `host_wr_gnt` is 0. Otherwise `host_wr_gnt` follows `host_wr_req`.
- R5: With `save_en` high, six writes follow acceptance on consecutive cycles, starting with the edge that sets the lock. They use addresses 0 to 5, and address i carries `time_bus[8*i+7:8*i]` as latched at acceptance. Field 0 is hundredths and field 5 is month. Later changes on `time_bus` do not alter the saved bytes.
- R6: With `save_en` low, acceptance locks the block and raises the interrupt, but `sv_we` stays 0.
- R7: Status bit 4 (save done) is set on the edge after the last save write. It is cleared by the next accepted failure or by a status write with bit 4 set.
- R8: After both synchronized monitors return low, the block spends `settle_cnt`+1 cycles settling and then waits for a status read. The read (`st_rd`) releases the lock on the next edge.
- R9: A status read made before the settle time has elapsed has no effect: the lock stays set.
- R10: Status bit 0 (first battery application) is 1 after reset. It is cleared by a status write with bit 0 set. Writing 0 to it has no effect, and nothing but reset sets it again.
- R11: Status bit 1 is 1 when neither synchronized monitor shows a failure. Bit 2 mirrors `bat_low` two edges later. Bit 5 is the lock. Status writes do not change bits 1, 2 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pf_in | input | 1 | Asynchronous power-fail comparator output |
| bat_over_main | input | 1 | Asynchronous flag: battery above main supply |
| bat_low | input | 1 | Asynchronous low-battery comparator output |
| save_en | input | 1 | Enables the time snapshot on failure |
| settle_cnt | input | SETTLE_W | Settle length after power returns |
| time_bus | input | 48 | Clock counters, byte 0 hundredths to byte 5 month |
| sv_we | output | 1 | Save RAM write enable |
| sv_addr | output | 3 | Save RAM address |
| sv_data | output | 8 | Save RAM write data |
| irq_pf | output | 1 | Power-fail interrupt |
| host_wr_req | input | 1 | Host register write request |
| host_wr_gnt | output | 1 | Host write allowed through |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe (write one to clear) |
| st_wdata | input | 8 | Status write data |
| st_rdata | output | 8 | Status read data |

## Verification
The filter is swept over pulse lengths from 1 to 6 cycles on each of the two failure sources. This locates the exact acceptance threshold and shows that the battery comparator follows the same path as the power-fail input.

A full cycle with saving enabled checks the following:
- the edge on which the lock appears
- every save address and byte, while the time bus is changed under the snapshot
- the done flag

Release is then tried with a status read on the last settle cycle, which must be ignored, and with a read after it, which must take effect. A second failure with saving disabled is then followed by a zero settle length. This separates the clearing of the done flag, the absence of writes, and the shortest release path. Status writes of zeros, of the read-only bits, and of each one-to-clear bit probe every status field.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 6;
    localparam int BUS_W      = NUM_FIELDS * BYTE_W;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    // status bit positions
    localparam int SB_FIRST  = 0;
    localparam int SB_SYSPWR = 1;
    localparam int SB_BATLOW = 2;
    localparam int SB_PFINT  = 3;
    localparam int SB_DONE   = 4;
    localparam int SB_LOCK   = 5;

    typedef enum logic [2:0] {
        PS_RUN,
        PS_SAVE,
        PS_HOLD,
        PS_SETTLE,
        PS_WAITRD
    } pf_state_e;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } save_wr_s;

    typedef struct packed {
        logic detect;     // failure accepted this cycle
        logic save_last;  // final save write this cycle
        logic lock;       // host lockout active
    } seq_evt_s;

    function automatic logic [BYTE_W-1:0] pick_field(
        input logic [BUS_W-1:0] bus,
        input logic [IDX_W-1:0] idx
    );
        return bus[int'(idx)*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/pwrfail_sync.sv
module pwrfail_sync #(
    parameter int NSIG   = 3,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] async_in,
    output logic [NSIG-1:0] sync_out
);

    for (genvar g = 0; g < NSIG; g++) begin : g_bit
        logic [STAGES-1:0] stg;
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= async_in[g];
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], async_in[g]};
            end
        end
        assign sync_out[g] = stg[STAGES-1];
    end

endmodule

// File: rtl/pwrfail_filter.sv
module pwrfail_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic accepted
);

    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (!level)         cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign accepted = (cnt == CNT_MAX);

endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
    import pwrfail_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accepted,
    input  logic                fail_now,
    input  logic                save_en,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic [BUS_W-1:0]    time_bus,
    input  logic                status_rd,
    output save_wr_s            wr,
    output seq_evt_s            evt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FIELDS - 1);

    pf_state_e           st, st_nx;
    logic [IDX_W-1:0]    idx;
    logic [SETTLE_W-1:0] sc;
    logic [BUS_W-1:0]    snap;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_RUN;
            idx  <= '0;
            sc   <= '0;
            snap <= '0;
        end else begin
            st <= st_nx;
            if (st == PS_RUN && accepted) snap <= time_bus;
            if (st == PS_SAVE) idx <= idx + 1'b1;
            else               idx <= '0;
            if (st == PS_SETTLE) sc <= sc + 1'b1;
            else                 sc <= '0;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            PS_RUN:    if (accepted) st_nx = save_en ? PS_SAVE : PS_HOLD;
            PS_SAVE:   if (idx == LAST_IDX) st_nx = PS_HOLD;
            PS_HOLD:   if (!fail_now) st_nx = PS_SETTLE;
            PS_SETTLE: begin
                if (fail_now)               st_nx = PS_HOLD;
                else if (sc == settle_cnt)  st_nx = PS_WAITRD;
            end
            PS_WAITRD: begin
                if (fail_now)       st_nx = PS_HOLD;
                else if (status_rd) st_nx = PS_RUN;
            end
            default:   st_nx = PS_RUN;
        endcase
    end

    always_comb begin
        wr.we   = (st == PS_SAVE);
        wr.addr = idx;
        wr.data = pick_field(snap, idx);
        evt.detect    = (st == PS_RUN) && accepted;
        evt.save_last = (st == PS_SAVE) && (idx == LAST_IDX);
        evt.lock      = (st != PS_RUN);
    end

endmodule

// File: rtl/pwrfail_status.sv
module pwrfail_status
    import pwrfail_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_s          evt,
    input  logic              fail_now,
    input  logic              bat_low_s,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);

    logic first_bat, pend, done;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_bat <= 1'b1;
            pend      <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (wr_en && wdata[SB_FIRST]) first_bat <= 1'b0;

            if (evt.detect)                    pend <= 1'b1;
            else if (wr_en && wdata[SB_PFINT]) pend <= 1'b0;

            if (evt.detect)                   done <= 1'b0;
            else if (evt.save_last)           done <= 1'b1;
            else if (wr_en && wdata[SB_DONE]) done <= 1'b0;
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[SB_FIRST]  = first_bat;
        rdata[SB_SYSPWR] = !fail_now;
        rdata[SB_BATLOW] = bat_low_s;
        rdata[SB_PFINT]  = pend;
        rdata[SB_DONE]   = done;
        rdata[SB_LOCK]   = evt.lock;
    end

    assign irq = pend;

endmodule

// File: rtl/pwrfail_tsave.sv
module pwrfail_tsave
    import pwrfail_pkg::*;
#(
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pf_in,
    input  logic                bat_over_main,
    input  logic                bat_low,
    input  logic                save_en,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic [BUS_W-1:0]    time_bus,
    output logic                sv_we,
    output logic [IDX_W-1:0]    sv_addr,
    output logic [BYTE_W-1:0]   sv_data,
    output logic                irq_pf,
    input  logic                host_wr_req,
    output logic                host_wr_gnt,
    input  logic                st_rd,
    input  logic                st_wr,
    input  logic [BYTE_W-1:0]   st_wdata,
    output logic [BYTE_W-1:0]   st_rdata
);

    localparam int NMON = 3;

    logic [NMON-1:0] mon_s;
    logic            fail_now;
    logic            accepted;
    save_wr_s        wr;
    seq_evt_s        evt;

    pwrfail_sync #(.NSIG(NMON), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({bat_low, bat_over_main, pf_in}),
        .sync_out (mon_s)
    );

    assign fail_now = mon_s[0] | mon_s[1];

    pwrfail_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .level    (fail_now),
        .accepted (accepted)
    );

    pwrfail_seq #(.SETTLE_W(SETTLE_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accepted   (accepted),
        .fail_now   (fail_now),
        .save_en    (save_en),
        .settle_cnt (settle_cnt),
        .time_bus   (time_bus),
        .status_rd  (st_rd),
        .wr         (wr),
        .evt        (evt)
    );

    pwrfail_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .fail_now  (fail_now),
        .bat_low_s (mon_s[2]),
        .wr_en     (st_wr),
        .wdata     (st_wdata),
        .rdata     (st_rdata),
        .irq       (irq_pf)
    );

    assign sv_we       = wr.we;
    assign sv_addr     = wr.addr;
    assign sv_data     = wr.data;
    assign host_wr_gnt = host_wr_req & ~evt.lock;

endmodule

// File: rtl/pwrfail_tsave_chk.sv
module pwrfail_tsave_chk
    import pwrfail_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_pf,
    input logic              sv_we,
    input logic [IDX_W-1:0]  sv_addr,
    input logic              st_rd,
    input logic [BYTE_W-1:0] st_rdata
);

    logic locked;
    assign locked = st_rdata[SB_LOCK];

    AST_LOCK_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> irq_pf) else $error("lock without interrupt"); // R3

    AST_SAVE_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
        sv_we |-> locked) else $error("save write while unlocked"); // R5

    AST_SAVE_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(sv_we) |-> (sv_addr == '0)) else $error("save does not start at 0"); // R5

    AST_SAVE_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (sv_we && $past(sv_we)) |-> (sv_addr == IDX_W'($past(sv_addr) + 1'b1)))
        else $error("save address skipped"); // R5

    AST_UNLOCK_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(st_rd)) else $error("unlock without read"); // R8

    AST_FIRST_NO_RESET: assert property (@(posedge clk) disable iff (rst)
        !st_rdata[SB_FIRST] |=> !st_rdata[SB_FIRST]) else $error("first flag set again"); // R10

endmodule

bind pwrfail_tsave pwrfail_tsave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_pf   (irq_pf),
    .sv_we    (sv_we),
    .sv_addr  (sv_addr),
    .st_rd    (st_rd),
    .st_rdata (st_rdata)
);

// File: tb/pwrfail_tsave_test.sv
`timescale 1ns/1ps
module pwrfail_tsave_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pf_in = 1'b0, bat_over_main = 1'b0, bat_low = 1'b0;
    logic        save_en = 1'b1;
    logic [7:0]  settle_cnt = 8'd3;
    logic [47:0] time_bus = '0;
    logic        sv_we, irq_pf, host_wr_gnt;
    logic [2:0]  sv_addr;
    logic [7:0]  sv_data, st_rdata;
    logic        host_wr_req = 1'b0, st_rd = 1'b0, st_wr = 1'b0;
    logic [7:0]  st_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrfail_tsave uut (
        .clk(clk), .rst(rst), .pf_in(pf_in), .bat_over_main(bat_over_main),
        .bat_low(bat_low), .save_en(save_en), .settle_cnt(settle_cnt),
        .time_bus(time_bus), .sv_we(sv_we), .sv_addr(sv_addr), .sv_data(sv_data),
        .irq_pf(irq_pf), .host_wr_req(host_wr_req), .host_wr_gnt(host_wr_gnt),
        .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata), .st_rdata(st_rdata)
    );

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int base, input int i);
        return 8'((base + 13 * i) % 256);
    endfunction

    function automatic logic [47:0] make_bus(input int base);
        logic [47:0] b;
        for (int i = 0; i < 6; i++) b[i*8 +: 8] = fbyte(base, i);
        return b;
    endfunction

    task automatic do_reset();
        rst = 1'b1; pf_in = 1'b0; bat_over_main = 1'b0; bat_low = 1'b0;
        st_rd = 1'b0; st_wr = 1'b0; st_wdata = '0; host_wr_req = 1'b0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic st_write(input logic [7:0] d);
        st_wr = 1'b1; st_wdata = d; tick(1); st_wr = 1'b0; st_wdata = '0;
    endtask

    task automatic st_read();
        st_rd = 1'b1; tick(1); st_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int wcount;
        do_reset();
        // reset state, R10 R11
        check("R10 R11 reset status", st_rdata, 8'h03);
        check("R3 reset irq", irq_pf, 0);
        host_wr_req = 1'b1; #1;
        check("R4 grant when unlocked", host_wr_gnt, 1);
        host_wr_req = 1'b0;

        bat_low = 1'b1; tick(1);
        check("R11 bat_low after one edge", st_rdata[2], 0);
        tick(1);
        check("R11 bat_low after two edges", st_rdata[2], 1);
        st_write(8'h00);
        check("R10 write zero keeps first flag", st_rdata, 8'h07);
        st_write(8'h26);
        check("R11 write to live bits ignored", st_rdata, 8'h07);
        st_write(8'h01);
        check("R10 write one clears first flag", st_rdata, 8'h06);
        tick(3);
        check("R10 first flag stays clear", st_rdata[0], 0);

        // R1 R2 pulse-length sweep on both sources
        for (int src = 0; src < 2; src++) begin
            for (int len = 1; len <= 6; len++) begin
                do_reset();
                save_en = 1'b0;
                if (src == 0) pf_in = 1'b1; else bat_over_main = 1'b1;
                tick(len);
                pf_in = 1'b0; bat_over_main = 1'b0;
                tick(12);
                check($sformatf("R1 R2 src%0d len%0d lock", src, len), st_rdata[5], (len >= 4) ? 1 : 0);
                check($sformatf("R1 R3 src%0d len%0d irq", src, len), irq_pf, (len >= 4) ? 1 : 0);
            end
        end

        // full cycle with save, R1 R3 R4 R5 R7 R8 R9
        do_reset();
        save_en = 1'b1; settle_cnt = 8'd3; time_bus = make_bus(40); host_wr_req = 1'b1;
        pf_in = 1'b1;
        tick(6);
        check("R1 not locked after 6 edges", st_rdata[5], 0);
        check("R4 grant before lock", host_wr_gnt, 1);
        tick(1);
        check("R1 locked after 7 edges", st_rdata[5], 1);
        check("R3 irq with lock", irq_pf, 1);
        check("R4 grant blocked", host_wr_gnt, 0);
        check("R11 sys power bit low", st_rdata[1], 0);
        time_bus = make_bus(200);
        for (int i = 0; i < 6; i++) begin
            check($sformatf("R5 we %0d", i), sv_we, 1);
            check($sformatf("R5 addr %0d", i), sv_addr, i);
            check($sformatf("R5 data %0d", i), sv_data, fbyte(40, i));
            tick(1);
        end
        check("R5 writes stop", sv_we, 0);
        check("R7 done set", st_rdata[4], 1);

        pf_in = 1'b0;
        tick(6);
        check("R8 still locked in settle", st_rdata[5], 1);
        st_read();
        tick(2);
        check("R9 early read ignored", st_rdata[5], 1);
        check("R11 sys power bit back", st_rdata[1], 1);
        st_read();
        check("R8 released by read", st_rdata[5], 0);
        check("R4 grant restored", host_wr_gnt, 1);
        check("R3 irq survives read", irq_pf, 1);
        st_write(8'h08);
        check("R3 irq cleared by write", irq_pf, 0);

        // second failure without save, R6 R7
        save_en = 1'b0; settle_cnt = 8'd0;
        pf_in = 1'b1;
        tick(7);
        check("R6 locked", st_rdata[5], 1);
        check("R7 done cleared by new failure", st_rdata[4], 0);
        wcount = 0;
        for (int i = 0; i < 8; i++) begin
            if (sv_we) wcount++;
            tick(1);
        end
        check("R6 no save writes", wcount, 0);

        // zero settle, R8
        pf_in = 1'b0;
        tick(4);
        tick(5);
        check("R8 no release without read", st_rdata[5], 1);
        st_read();
        check("R8 release with zero settle", st_rdata[5], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule